// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst to a synchronous memory. The memory is given one start address, and the block then supplies up to four addresses without the address being presented again. Only the two lowest address bits move during a burst. The upper bits stay at the value that was loaded.

A single control input chooses the operation each cycle. When it is low, the block loads a new start address. When it is high, the block steps to the next beat. The ordering input is sampled at load time and picks one of two sequences:

- Linear: the start offset plus the beat count, modulo 4.
- Interleaved: the start offset XOR the beat count.

The access direction (read or write) is also captured at load time and held for every beat. Stepping ignores the write request, so the burst never changes direction part-way through. An active-low clock enable freezes all state. A synchronous reset returns the block to address zero, read direction, linear order.

Top module: `burst_addr_gen`

## Requirements
- R1: A high `rst` at a clock edge sets `cur_addr` to 0 and `dir_wr` to 0 (read), with the burst position and the latched ordering cleared to linear; this takes precedence over `clk_en_n`.
- R2: While `clk_en_n` is 1 at a clock edge, `cur_addr` and `dir_wr` keep their values, whatever `seq_step`, `mode_ilv`, `start_addr` and `wr_en` carry.
- R3: With `clk_en_n` 0 and `seq_step` 0 at an edge, the next `cur_addr` equals `start_addr` and the next `dir_wr` equals `wr_en`; `mode_ilv` is latched as the burst ordering (0 linear, 1 interleaved).
- R4: With `clk_en_n` 0 and `seq_step` 1, bits ADDR_W-1 down to 2 of `cur_addr` do not change.
- R5: In linear order, after n steps since the load, `cur_addr[1:0]` equals (start[1:0] + n) mod 4.
- R6: In interleaved order, after n steps since the load, `cur_addr[1:0]` equals start[1:0] XOR (n mod 4).
- R7: After four steps the address returns to the loaded start address, and further steps repeat the same four-beat sequence.
- R8: Steps leave `dir_wr` unchanged whatever `wr_en` is.
- R9: Changing `mode_ilv` during a burst has no effect on the sequence until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| seq_step | input | 1 | 0 loads a start address, 1 steps the burst |
| mode_ilv | input | 1 | Burst ordering at load: 0 linear, 1 interleaved |
| start_addr | input | ADDR_W | Start address captured on load |
| wr_en | input | 1 | Access direction captured on load: 1 write, 0 read |
| cur_addr | output | ADDR_W | Address of the current beat |
| dir_wr | output | 1 | Held access direction: 1 write, 0 read |

## Verification
The bench targets the following corner cases, with the failure each one exposes:

- **Start offset of 3 in both orderings.** A design that adds where it should XOR, or the reverse, gives a wrong second beat in this case.
- **Stepping past the fourth beat.** A design that carries into bit 2, or stops instead of wrapping, disturbs the upper address bits.
- **Toggling `wr_en` and `mode_ilv` in the middle of a burst.** A design that samples either input on a step flips the direction or reorders the remaining beats.
- **Load and step requests under an inactive clock enable, and a reset under an inactive enable.** A design that gates reset with the enable, or ignores the enable, moves when it should hold or holds when it should clear.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int OFS_W     = 2;
    localparam int BURST_LEN = 1 << OFS_W;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// Beat counter: cleared on load, incremented on step, frozen while disabled.
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic load,
    input  logic step,
    output ofs_t beat_o
);

    ofs_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (!hold) begin
            if (load) begin
                beat_d = '0;
            end else if (step) begin
                beat_d = beat_q + ofs_t'(1);   // wraps modulo BURST_LEN
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/burst_order_map.sv
// Maps start offset and beat count to the low address bits.
module burst_order_map
    import burst_pkg::*;
(
    input  ofs_t   start_ofs,
    input  ofs_t   beat,
    input  order_e order,
    output ofs_t   lo_addr
);

    always_comb begin
        unique case (order)
            ORD_INTERLEAVE: lo_addr = start_ofs ^ beat;
            default:        lo_addr = start_ofs + beat;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              seq_step,
    input  logic              mode_ilv,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              wr_en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              dir_wr
);

    localparam int HI_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        ofs_t            ofs;
        order_e          ord;
        dir_e            dir;
    } ctl_t;

    ctl_t state_d, state_q;
    ofs_t beat;
    ofs_t lo_addr;
    logic do_load;

    assign do_load = ~seq_step;

    always_comb begin
        state_d = state_q;
        if (!clk_en_n && do_load) begin
            state_d.hi  = start_addr[ADDR_W-1:OFS_W];
            state_d.ofs = start_addr[OFS_W-1:0];
            state_d.ord = mode_ilv ? ORD_INTERLEAVE : ORD_LINEAR;
            state_d.dir = wr_en ? DIR_WRITE : DIR_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{hi: '0, ofs: '0, ord: ORD_LINEAR, dir: DIR_READ};
        end else begin
            state_q <= state_d;
        end
    end

    burst_beat_ctr u_beat (
        .clk    (clk),
        .rst    (rst),
        .hold   (clk_en_n),
        .load   (do_load),
        .step   (seq_step),
        .beat_o (beat)
    );

    burst_order_map u_map (
        .start_ofs (state_q.ofs),
        .beat      (beat),
        .order     (state_q.ord),
        .lo_addr   (lo_addr)
    );

    assign cur_addr = {state_q.hi, lo_addr};
    assign dir_wr   = (state_q.dir == DIR_WRITE);

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              seq_step,
    input logic              mode_ilv,
    input logic [ADDR_W-1:0] start_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              dir_wr,
    input logic              ord_lat
);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && !dir_wr && !ord_lat));

    // R2
    a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> (rst || ($stable(cur_addr) && $stable(dir_wr))));

    // R3
    a_r3_load_captures: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !seq_step) |=>
            (cur_addr == $past(start_addr) && dir_wr == $past(wr_en) && ord_lat == $past(mode_ilv)));

    // R4
    a_r4_upper_stable: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && seq_step) |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

    // R5
    a_r5_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && seq_step && !ord_lat) |=> cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1);

    // R6
    a_r6_ilv_bit0_toggles: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && seq_step && ord_lat) |=> cur_addr[0] != $past(cur_addr[0]));

    // R8
    a_r8_dir_held_on_step: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && seq_step) |=> $stable(dir_wr));

    // R9
    a_r9_order_held_on_step: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && seq_step) |=> $stable(ord_lat));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .seq_step   (seq_step),
    .mode_ilv   (mode_ilv),
    .start_addr (start_addr),
    .wr_en      (wr_en),
    .cur_addr   (cur_addr),
    .dir_wr     (dir_wr),
    .ord_lat    (state_q.ord)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          seq_step = 1'b0;
    logic          mode_ilv = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          dir_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;
    bit            m_ilv  = 0;
    bit            m_dir  = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk        (clk),
        .rst        (rst),
        .clk_en_n   (clk_en_n),
        .seq_step   (seq_step),
        .mode_ilv   (mode_ilv),
        .start_addr (start_addr),
        .wr_en      (wr_en),
        .cur_addr   (cur_addr),
        .dir_wr     (dir_wr)
    );

    function automatic logic [AW-1:0] model_addr();
        int off;
        int lo;
        off = int'(m_base[1:0]);
        lo  = m_ilv ? (off ^ m_beat) : ((off + m_beat) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic cycle(input bit r, input bit en_n, input bit stp, input bit md,
                         input logic [AW-1:0] a, input bit w, input string tag);
        logic [AW-1:0] exp_a;
        rst = r; clk_en_n = en_n; seq_step = stp; mode_ilv = md;
        start_addr = a; wr_en = w;
        if (r) begin
            m_base = '0; m_beat = 0; m_ilv = 0; m_dir = 0;
        end else if (!en_n) begin
            if (!stp) begin
                m_base = a; m_beat = 0; m_ilv = md; m_dir = w;
            end else begin
                m_beat = (m_beat + 1) % 4;
            end
        end
        @(negedge clk);
        exp_a = model_addr();
        checks++;
        if (cur_addr !== exp_a) begin
            fails++;
            $display("FAIL %s cur_addr actual=%h expected=%h", tag, cur_addr, exp_a);
        end
        checks++;
        if (dir_wr !== m_dir) begin
            fails++;
            $display("FAIL %s dir_wr actual=%0b expected=%0b", tag, dir_wr, m_dir);
        end
    endtask

    initial begin
        // R1 reset state
        cycle(1, 0, 0, 1, 18'h3FFFF, 1, "R1");
        cycle(1, 1, 1, 0, 18'h00000, 0, "R1");

        // R3 load linear, then R5 / R7 / R8 / R9 stepping with noisy wr_en and mode
        cycle(0, 0, 0, 0, 18'h2A5C2, 1, "R3");
        cycle(0, 0, 1, 1, 18'h11111, 0, "R5");
        cycle(0, 0, 1, 0, 18'h00000, 0, "R8");
        cycle(0, 0, 1, 1, 18'h3FFFF, 0, "R9");
        cycle(0, 0, 1, 0, 18'h00000, 1, "R7");
        cycle(0, 0, 1, 1, 18'h00000, 0, "R7");
        cycle(0, 0, 1, 0, 18'h00000, 0, "R4");

        // R2 disabled: load and step requests ignored
        cycle(0, 1, 0, 1, 18'h00001, 0, "R2");
        cycle(0, 1, 1, 1, 18'h12345, 0, "R2");

        // R1 reset beats an inactive enable
        cycle(1, 1, 1, 1, 18'h3FFFF, 1, "R1");

        // R6 interleaved from offset 3, read
        cycle(0, 0, 0, 1, 18'h1F003, 0, "R3");
        for (int i = 0; i < 6; i++) cycle(0, 0, 1, i[0], 18'h0, 1, "R6");

        // R5 linear from offset 3 (wrap through 0)
        cycle(0, 0, 0, 0, 18'h00FF3, 1, "R3");
        for (int i = 0; i < 5; i++) cycle(0, 0, 1, 1, 18'h0, 0, "R5");

        // R6 interleaved from offsets 1 and 2
        cycle(0, 0, 0, 1, 18'h20001, 1, "R3");
        for (int i = 0; i < 4; i++) cycle(0, 0, 1, 0, 18'h0, 0, "R6");
        cycle(0, 0, 0, 1, 18'h30002, 0, "R3");
        for (int i = 0; i < 4; i++) cycle(0, 0, 1, 0, 18'h0, 1, "R6");

        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [AW-1:0] a;
            bit en_n, stp, md, w;
            op = $urandom_range(0, 9);
            a  = AW'($urandom);
            md = 1'($urandom);
            w  = 1'($urandom);
            en_n = (op == 0);
            stp  = (op > 2);
            if (op == 9 && i % 50 == 0)
                cycle(1, 0, stp, md, a, w, "R1");
            else if (en_n)
                cycle(0, 1, stp, md, a, w, "R2");
            else if (!stp)
                cycle(0, 0, 0, md, a, w, "R3");
            else
                cycle(0, 0, 1, md, a, w, m_ilv ? "R6" : "R5");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule